// File: doc/BRIEF.md
# Direct-Mapped Address Translation Cache with Access Rights

This block turns a virtual byte address into a physical one for a single requester. It keeps a small direct-mapped cache of page mappings. Each slot holds a full virtual page number as its tag, a valid flag, six access-right bits and a physical page number. Pages are 4 KiB, so the low 12 address bits pass straight through and the bits above them form the virtual page number.

A lookup that finds its mapping answers one cycle after the request is accepted. A lookup that misses raises a request to an external page-table walker and stalls the requester until the walker replies. A valid reply is written into the slot and then checked. After the mapping is found, the rights check uses the privilege level and the kind of access (read, write or instruction fetch). The block then returns either the physical address or a fault code that names the access kind.

With translation switched off, the block makes the mapping itself: physical equals virtual, every right is granted, and the mapping is valid only below a configured memory size. No walk is requested in this mode. A flush input empties the cache.

Top module: `vtlb_dm`

## Requirements
- R1: After reset, rsp_valid and walk_req are 0, req_ready is 1 and every slot is empty, so the first access to any page misses.
- R2: A request accepted while its slot is valid and its tag equals the full virtual page number (address bits 31:12) produces rsp_valid in the next cycle and raises no walk. The physical address is {page number, address bits 11:0}.
- R3: When translation is on and a request misses, walk_req rises with walk_vpn equal to the full virtual page number. req_ready stays 0 until walk_ack is seen, and the response appears in the cycle after walk_ack.
- R4: A valid walk reply is stored in slot (page number mod ENTRIES) with the full page number as tag. Later accesses to that page use the stored mapping even if the page table has since changed. An access to another page with the same low index bits misses and replaces the slot.
- R5: An invalid walk reply (walk_v = 0) makes the access fault and is not stored, so the next access to that page walks again.
- R6: A write (req_kind = 1) needs rights bit 4 in supervisor mode (priv_sup = 1) or bit 1 in user mode.
- R7: A read (req_kind = 0, and also req_kind = 3) needs rights bit 3 in supervisor mode or bit 0 in user mode.
- R8: A fetch (req_kind = 2) needs rights bit 5 in supervisor mode or bit 2 in user mode.
- R9: A faulting response has rsp_fault = 1 and rsp_paddr = 0. rsp_cause is 3 for a write, 1 for a fetch and 2 for a read. A good response has rsp_cause = 0.
- R10: With vm_on = 0, a miss raises no walk and answers in the next cycle. It uses an identity mapping with all six rights, valid only when the address is below MEM_BYTES, and a valid identity mapping is stored like a walk reply.
- R11: flush empties every slot by the next cycle. An access after a flush misses even if its page was cached before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties all slots |
| vm_on | input | 1 | 1 = translate through page tables, 0 = identity mode |
| priv_sup | input | 1 | 1 = supervisor, 0 = user |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | ADDR_W | Virtual byte address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | ADDR_W | Physical address, 0 on fault |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 0 none, 1 fetch fault, 2 read fault, 3 write fault |
| walk_req | output | 1 | Page-table walk wanted |
| walk_vpn | output | ADDR_W-12 | Page number to walk |
| walk_ack | input | 1 | Walk reply present |
| walk_v | input | 1 | Reply mapping is valid |
| walk_perm | input | 6 | Reply rights: bit0 user read, 1 user write, 2 user fetch, 3 sup read, 4 sup write, 5 sup fetch |
| walk_ppn | input | ADDR_W-12 | Reply physical page number |

## Verification
A slot holding a wrong tag or a stale valid flag shows up at once. Either an expected hit raises walk_req, or an expected walk never comes, and the walk counter exposes this within the cycle after acceptance. Corrupted stored rights or page numbers appear in the response one cycle after a hit, as a wrong rsp_paddr, rsp_fault or rsp_cause. Because of this, the bench changes the page table after a fill and then repeats the access, which shows whether the cached copy or the walker was used. A lost flush shows up on the next access to a page that was cached before, which should walk again.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int OFF_W = 12;
  localparam int PERM_W = 6;

  // rights bit positions inside a stored mapping
  localparam int PB_UR = 0;
  localparam int PB_UW = 1;
  localparam int PB_UX = 2;
  localparam int PB_SR = 3;
  localparam int PB_SW = 4;
  localparam int PB_SX = 5;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_READ2 = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_FETCH = 2'd1,
    FLT_READ  = 2'd2,
    FLT_WRITE = 2'd3
  } fault_e;

  function automatic fault_e fault_for(access_e k);
    case (k)
      ACC_WRITE: return FLT_WRITE;
      ACC_FETCH: return FLT_FETCH;
      default:   return FLT_READ;
    endcase
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store import tlb_pkg::*; #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [VPN_W-1:0]  rd_tag,
  output logic [PERM_W-1:0] rd_perm,
  output logic [PPN_W-1:0]  rd_ppn,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_tag,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [PPN_W-1:0]  wr_ppn
);
  localparam int DAT_W = PERM_W + PPN_W;

  // tag and payload live in plain arrays (distributed RAM friendly);
  // valid flags are flops so a flush can clear them all in one cycle
  logic [VPN_W-1:0] tag_mem [ENTRIES];
  logic [DAT_W-1:0] dat_mem [ENTRIES];
  logic [ENTRIES-1:0] vld;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      dat_mem[wr_idx] <= {wr_perm, wr_ppn};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) vld <= '0;
    else if (wr_en)   vld[wr_idx] <= 1'b1;
  end

  assign rd_vld  = vld[rd_idx];
  assign rd_tag  = tag_mem[rd_idx];
  assign rd_perm = dat_mem[rd_idx][DAT_W-1:PPN_W];
  assign rd_ppn  = dat_mem[rd_idx][PPN_W-1:0];

  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0));
endmodule

// File: rtl/tlb_bare_map.sv
module tlb_bare_map import tlb_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter longint unsigned MEM_BYTES = 64'h0010_0000
)(
  input  logic [ADDR_W-1:0]       vaddr,
  output logic                    map_v,
  output logic [PERM_W-1:0]       map_perm,
  output logic [ADDR_W-OFF_W-1:0] map_ppn
);
  localparam logic [ADDR_W:0] LIMIT = MEM_BYTES[ADDR_W:0];

  assign map_v    = ({1'b0, vaddr} < LIMIT);
  assign map_perm = '1;
  assign map_ppn  = vaddr[ADDR_W-1:OFF_W];
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm import tlb_pkg::*; #(
  parameter int ADDR_W = 32
)(
  input  logic                    pte_v,
  input  logic [PERM_W-1:0]       perm,
  input  logic [ADDR_W-OFF_W-1:0] ppn,
  input  logic [OFF_W-1:0]        offset,
  input  logic [1:0]              kind,
  input  logic                    sup,
  output logic                    ok,
  output fault_e                  cause,
  output logic [ADDR_W-1:0]       paddr
);
  access_e k;
  logic    right;

  assign k = access_e'(kind);

  always_comb begin
    case (k)
      ACC_WRITE: right = sup ? perm[PB_SW] : perm[PB_UW];
      ACC_FETCH: right = sup ? perm[PB_SX] : perm[PB_UX];
      default:   right = sup ? perm[PB_SR] : perm[PB_UR];
    endcase
  end

  assign ok    = pte_v && right;
  assign cause = ok ? FLT_NONE : fault_for(k);
  assign paddr = ok ? {ppn, offset} : '0;
endmodule

// File: rtl/vtlb_dm.sv
module vtlb_dm import tlb_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 32,   // power of two: index is page number mod ENTRIES
  parameter longint unsigned MEM_BYTES = 64'h0010_0000
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    vm_on,
  input  logic                    priv_sup,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_vaddr,
  input  logic [1:0]              req_kind,
  output logic                    rsp_valid,
  output logic [ADDR_W-1:0]       rsp_paddr,
  output logic                    rsp_fault,
  output logic [1:0]              rsp_cause,
  output logic                    walk_req,
  output logic [ADDR_W-OFF_W-1:0] walk_vpn,
  input  logic                    walk_ack,
  input  logic                    walk_v,
  input  logic [PERM_W-1:0]       walk_perm,
  input  logic [ADDR_W-OFF_W-1:0] walk_ppn
);
  localparam int VPN_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  typedef enum logic {ST_IDLE, ST_WALK} st_e;
  st_e state;

  logic [ADDR_W-1:0] q_vaddr;
  logic [1:0]        q_kind;
  logic              q_sup;
  logic [VPN_W-1:0]  q_vpn;
  logic [VPN_W-1:0]  vpn_in;
  logic [IDX_W-1:0]  idx_in;

  assign vpn_in = req_vaddr[ADDR_W-1:OFF_W];
  assign idx_in = vpn_in[IDX_W-1:0];
  assign q_vpn  = q_vaddr[ADDR_W-1:OFF_W];

  // slot storage
  logic              rd_vld;
  logic [VPN_W-1:0]  rd_tag;
  logic [PERM_W-1:0] rd_perm;
  logic [VPN_W-1:0]  rd_ppn;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [VPN_W-1:0]  wr_tag;
  logic [PERM_W-1:0] wr_perm;
  logic [VPN_W-1:0]  wr_ppn;

  tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .PPN_W(VPN_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .rd_idx(idx_in), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_perm(rd_perm), .rd_ppn(rd_ppn),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_perm(wr_perm), .wr_ppn(wr_ppn)
  );

  // identity mapping for untranslated mode
  logic              bare_v;
  logic [PERM_W-1:0] bare_perm;
  logic [VPN_W-1:0]  bare_ppn;

  tlb_bare_map #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_bare (
    .vaddr(req_vaddr), .map_v(bare_v), .map_perm(bare_perm), .map_ppn(bare_ppn)
  );

  logic hit;
  assign hit = rd_vld && (rd_tag == vpn_in);

  // one rights checker, fed from the slot, the identity map or the walk reply
  logic              c_v;
  logic [PERM_W-1:0] c_perm;
  logic [VPN_W-1:0]  c_ppn;
  logic [OFF_W-1:0]  c_off;
  logic [1:0]        c_kind;
  logic              c_sup;
  logic              chk_ok;
  fault_e            chk_cause;
  logic [ADDR_W-1:0] chk_paddr;

  always_comb begin
    if (state == ST_WALK) begin
      c_v    = walk_v;
      c_perm = walk_perm;
      c_ppn  = walk_ppn;
      c_off  = q_vaddr[OFF_W-1:0];
      c_kind = q_kind;
      c_sup  = q_sup;
    end else begin
      c_off  = req_vaddr[OFF_W-1:0];
      c_kind = req_kind;
      c_sup  = priv_sup;
      if (hit) begin
        c_v    = 1'b1;
        c_perm = rd_perm;
        c_ppn  = rd_ppn;
      end else begin
        c_v    = bare_v;
        c_perm = bare_perm;
        c_ppn  = bare_ppn;
      end
    end
  end

  tlb_perm #(.ADDR_W(ADDR_W)) u_perm (
    .pte_v(c_v), .perm(c_perm), .ppn(c_ppn), .offset(c_off),
    .kind(c_kind), .sup(c_sup),
    .ok(chk_ok), .cause(chk_cause), .paddr(chk_paddr)
  );

  // fill control
  logic fill_bare, fill_walk;
  assign fill_bare = (state == ST_IDLE) && req_valid && !hit && !vm_on && bare_v;
  assign fill_walk = (state == ST_WALK) && walk_ack && walk_v;
  assign wr_en     = fill_bare || fill_walk;
  assign wr_idx    = fill_walk ? q_vpn[IDX_W-1:0] : idx_in;
  assign wr_tag    = fill_walk ? q_vpn : vpn_in;
  assign wr_perm   = fill_walk ? walk_perm : bare_perm;
  assign wr_ppn    = fill_walk ? walk_ppn : bare_ppn;

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= FLT_NONE;
      walk_req  <= 1'b0;
      walk_vpn  <= '0;
      q_vaddr   <= '0;
      q_kind    <= '0;
      q_sup     <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (hit || !vm_on) begin
              rsp_valid <= 1'b1;
              rsp_paddr <= chk_paddr;
              rsp_fault <= !chk_ok;
              rsp_cause <= chk_cause;
            end else begin
              q_vaddr  <= req_vaddr;
              q_kind   <= req_kind;
              q_sup    <= priv_sup;
              walk_req <= 1'b1;
              walk_vpn <= vpn_in;
              state    <= ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (walk_ack) begin
            walk_req  <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_paddr <= chk_paddr;
            rsp_fault <= !chk_ok;
            rsp_cause <= chk_cause;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  hit_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && hit) |=> (rsp_valid && !walk_req));
  // R3
  walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn)));
  // R3
  walk_stall_chk: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> !req_ready);
  // R3
  walk_done_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req && walk_ack) |=> (rsp_valid && !walk_req && req_ready));
  // R9
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_cause != 2'd0 && rsp_paddr == '0));
endmodule

// File: tb/vtlb_dm_test.sv
`timescale 1ns/1ps
module vtlb_dm_test;
  localparam int AW = 32;
  localparam longint unsigned MEMB = 64'h0010_0000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, flush, vm_on, priv_sup, req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cause;
  logic        walk_req, walk_ack, walk_v;
  logic [19:0] walk_vpn, walk_ppn;
  logic [5:0]  walk_perm;

  vtlb_dm #(.ADDR_W(AW), .ENTRIES(32), .MEM_BYTES(MEMB)) uut (
    .clk(clk), .rst(rst), .flush(flush), .vm_on(vm_on), .priv_sup(priv_sup),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ack(walk_ack), .walk_v(walk_v),
    .walk_perm(walk_perm), .walk_ppn(walk_ppn)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int walks = 0;
  logic [19:0] exp_wvpn = '0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // page table seen by the walker: {valid, rights[5:0], ppn[19:0]}
  logic [26:0] pt [int unsigned];
  function automatic logic [26:0] mk(input bit v, input logic [5:0] p, input logic [19:0] n);
    return {v, p, n};
  endfunction
  function automatic logic [26:0] pt_get(input logic [19:0] vpn);
    if (pt.exists(int'(vpn))) return pt[int'(vpn)];
    return '0;
  endfunction

  // reference cache model built from the requirements
  bit          m_v   [32];
  logic [19:0] m_tag [32];
  logic [26:0] m_pte [32];

  // scoreboard queues
  logic [31:0] q_pa [$];
  bit          q_f  [$];
  logic [1:0]  q_c  [$];
  int          q_lat[$];
  int          q_acc[$];
  string       q_tag[$];

  // walker model
  initial begin
    walk_ack = 1'b0; walk_v = 1'b0; walk_perm = '0; walk_ppn = '0;
    forever begin
      @(negedge clk);
      if (walk_req) begin
        logic [26:0] e;
        walks++;
        check(walk_vpn == exp_wvpn, "R3", "walk page number", walk_vpn, exp_wvpn);
        repeat (2) begin
          @(negedge clk);
          check(req_ready == 1'b0, "R3", "ready while walking", req_ready, 0);
        end
        e = pt_get(walk_vpn);
        walk_v = e[26]; walk_perm = e[25:20]; walk_ppn = e[19:0]; walk_ack = 1'b1;
        @(negedge clk);
        walk_ack = 1'b0; walk_v = 1'b0; walk_perm = '0; walk_ppn = '0;
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (q_pa.size() == 0) begin
          check(1'b0, "R2", "unexpected response", 1, 0);
        end else begin
          logic [31:0] pa; bit f; logic [1:0] c; int lat; int acc; string tg;
          pa = q_pa.pop_front(); f = q_f.pop_front(); c = q_c.pop_front();
          lat = q_lat.pop_front(); acc = q_acc.pop_front(); tg = q_tag.pop_front();
          check(rsp_fault == f, tg, "fault", rsp_fault, f);
          check(rsp_cause == c, tg, "cause (R9)", rsp_cause, c);
          check(rsp_paddr == pa, tg, "paddr", rsp_paddr, pa);
          if (lat >= 0) check(cyc - acc == lat, tg, "latency", cyc - acc, lat);
        end
      end
    end
  end

  // driver: called at a negedge
  task automatic access(input logic [31:0] va, input logic [1:0] kind,
                        input bit sup, input string tg);
    logic [19:0] vpn; int idx; bit hit; bit wexp; logic [26:0] e;
    bit need; bit ok; logic [1:0] code; int w0;
    vpn = va[31:12]; idx = int'(vpn[4:0]);
    hit = m_v[idx] && (m_tag[idx] == vpn);
    wexp = 1'b0;
    if (hit) e = m_pte[idx];
    else if (!vm_on) e = mk(({1'b0, va} < MEMB[32:0]), 6'h3f, vpn);
    else begin e = pt_get(vpn); wexp = 1'b1; end
    if (!hit && e[26]) begin m_v[idx] = 1'b1; m_tag[idx] = vpn; m_pte[idx] = e; end
    case (kind)
      2'd1:    begin need = sup ? e[24] : e[21]; code = 2'd3; end
      2'd2:    begin need = sup ? e[25] : e[22]; code = 2'd1; end
      default: begin need = sup ? e[23] : e[20]; code = 2'd2; end
    endcase
    ok = e[26] && need;
    exp_wvpn = vpn;
    w0 = walks;
    req_vaddr = va; req_kind = kind; priv_sup = sup; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    q_pa.push_back(ok ? {e[19:0], va[11:0]} : 32'h0);
    q_f.push_back(!ok);
    q_c.push_back(ok ? 2'd0 : code);
    q_lat.push_back(wexp ? -1 : 0);
    q_acc.push_back(cyc + 1);
    q_tag.push_back(tg);
    @(negedge clk);
    req_valid = 1'b0;
    while (q_pa.size() != 0) @(negedge clk);
    check((walks - w0) == int'(wexp), tg, "walk count", walks - w0, int'(wexp));
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 32; i++) m_v[i] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; m_pte[i] = '0; end
    rst = 1'b1; flush = 1'b0; vm_on = 1'b1; priv_sup = 1'b1;
    req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    check(walk_req == 1'b0, "R1", "walk_req in reset", walk_req, 0);
    check(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    rst = 1'b0;
    @(negedge clk);

    // R1/R3/R4 first access misses and fills; R2 then hits
    pt[32'h12] = mk(1'b1, 6'h3f, 20'h00345);
    access(32'h0001_2abc, 2'd0, 1'b1, "R1 first miss");
    access(32'h0001_2010, 2'd0, 1'b0, "R2 hit");
    // R4 alias replaces slot, original then misses, then stale copy is used
    pt[32'h32] = mk(1'b1, 6'h3f, 20'h00777);
    access(32'h0003_2004, 2'd1, 1'b1, "R4 alias miss");
    access(32'h0001_2ff0, 2'd2, 1'b1, "R4 evicted page walks");
    pt[32'h12] = mk(1'b1, 6'h3f, 20'h00999);
    access(32'h0001_2444, 2'd0, 1'b1, "R4 cached mapping kept");

    // R5 invalid reply: fault, no fill
    access(32'h0004_0000, 2'd0, 1'b1, "R5 invalid read");
    access(32'h0004_0008, 2'd1, 1'b1, "R5 invalid write walks again");

    // rights
    pt[32'h100] = mk(1'b1, 6'b000001, 20'h00100);
    access(32'h0010_0010, 2'd0, 1'b1, "R7 sup read needs bit3");
    access(32'h0010_0020, 2'd0, 1'b0, "R7 user read bit0");
    access(32'h0010_0030, 2'd1, 1'b0, "R6 user write needs bit1");
    access(32'h0010_0040, 2'd2, 1'b0, "R8 user fetch needs bit2");
    access(32'h0010_0050, 2'd3, 1'b0, "R7 kind3 acts as read");
    pt[32'h101] = mk(1'b1, 6'b010000, 20'h00201);
    access(32'h0010_1100, 2'd1, 1'b1, "R6 sup write bit4");
    access(32'h0010_1104, 2'd1, 1'b0, "R6 user write denied");
    access(32'h0010_1108, 2'd0, 1'b1, "R7 sup read denied");
    pt[32'h102] = mk(1'b1, 6'b100010, 20'h00202);
    access(32'h0010_2200, 2'd2, 1'b1, "R8 sup fetch bit5");
    access(32'h0010_2204, 2'd2, 1'b0, "R8 user fetch denied");
    access(32'h0010_2208, 2'd1, 1'b0, "R6 user write bit1");
    pt[32'h103] = mk(1'b1, 6'b001100, 20'h00203);
    access(32'h0010_3300, 2'd2, 1'b0, "R8 user fetch bit2");
    access(32'h0010_3304, 2'd0, 1'b1, "R7 sup read bit3");
    access(32'h0010_3308, 2'd2, 1'b1, "R8 sup fetch denied R9");

    // R11 flush
    do_flush();
    access(32'h0001_2abc, 2'd0, 1'b1, "R11 after flush walks");
    access(32'h0010_3300, 2'd2, 1'b0, "R11 other page walks");

    // R10 identity mode
    vm_on = 1'b0;
    do_flush();
    access(32'h0005_4abc, 2'd1, 1'b0, "R10 identity write");
    access(32'h0005_4ab0, 2'd0, 1'b1, "R10 identity hit");
    access(32'h0020_0000, 2'd0, 1'b1, "R10 above memory read fault");
    access(32'h000f_fffc, 2'd2, 1'b0, "R10 last page fetch");
    access(32'h0010_0000, 2'd2, 1'b1, "R10 boundary fetch fault");
    vm_on = 1'b1;
    access(32'h0005_4000, 2'd0, 1'b0, "R10 identity entry cached");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule